// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which power state a small processor core drops into when it executes its idle instruction, and which events bring it back. Two software-written control bits choose among three sleep states. Plain idle stops only the CPU. Standby also stops the peripherals and the watchdog but leaves timer 1 running. Halt stops every clock. Each state has its own set of wake events. The block drives the clock-gating enables, a CPU stall line, the watchdog clock enable and a nonmaskable-interrupt request.

A tie-off input models a factory disable of the deep sleep states. While it is high, writes to the control bits are dropped and every idle instruction enters plain idle. A hard-watchdog flag makes external interrupt 1 raise a nonmaskable request while the core sits in standby or halt, so that the core can always be woken. Hardware reset is asynchronous and active low. It clears the control bits and returns the block to RUN from any state. No other state is cleared on entry to or exit from a sleep state.

Top module: `lpm_seq`

## Requirements
- R1: While `rstN` is low and after its release, `pwrState` is 0 (RUN), `ctrlBits` is 0, `cpuStall` and `nmiReq` are 0, and all four clock enables are 1. Reset takes effect immediately from any state, including HALT.
- R2: A write with `cfgWrEn` high and `lpDisable` low loads `cfgWrData` into `ctrlBits` at that clock edge. Bit 0 is power-down enable and bit 1 is halt select. `ctrlBits` shows the new value in the next cycle.
- R3: In RUN, `idleExec` with bit 0 at 0 moves the block to IDLE (`pwrState`=1) at the next edge, whatever bit 1 holds. IDLE gives `cpuStall`=1 and `cpuClkEn`=0, and keeps `periphClkEn`, `tmr1ClkEn` and `wdClkEn` at 1.
- R4: In RUN, `idleExec` with bits {1,0}=01 moves the block to STANDBY (`pwrState`=2). STANDBY gives `cpuStall`=1, `tmr1ClkEn`=1, and `cpuClkEn`=`periphClkEn`=`wdClkEn`=0.
- R5: In RUN, `idleExec` with bits {1,0}=11 moves the block to HALT (`pwrState`=3). HALT gives `cpuStall`=1 with all four clock enables at 0.
- R6: In STANDBY, `extInt1` or `tmr1Int` returns the block to RUN at the next edge, so `cpuStall` falls one cycle after the event is sampled.
- R7: In HALT, only `extInt1` returns the block to RUN. `tmr1Int` and `anyIntReq` leave it in HALT.
- R8: In IDLE, `anyIntReq` returns the block to RUN at the next edge. `extInt1` or `tmr1Int` alone leave it in IDLE.
- R9: While `lpDisable` is high, writes leave `ctrlBits` unchanged and `idleExec` in RUN always enters IDLE.
- R10: In STANDBY or HALT with `hardWdMode` high, a sampled `extInt1` raises `nmiReq` for exactly the next cycle. `nmiReq` stays 0 in every other case.
- R11: `idleExec` has no effect outside RUN.
- R12: The idle decision uses the control bits held before the edge, so a write in the same cycle as `idleExec` only affects later idle instructions. Sleep entry and exit leave `ctrlBits` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| cfgWrEn | input | 1 | Control-bit write strobe |
| cfgWrData | input | 2 | Write data: bit 0 power-down enable, bit 1 halt select |
| idleExec | input | 1 | Idle instruction executes this cycle |
| lpDisable | input | 1 | Deep sleep modes fused off |
| hardWdMode | input | 1 | Hard watchdog mode selected |
| extInt1 | input | 1 | External interrupt 1 event |
| tmr1Int | input | 1 | Timer 1 interrupt event |
| anyIntReq | input | 1 | Any enabled interrupt pending |
| ctrlBits | output | 2 | Current control bits {halt select, power-down enable} |
| pwrState | output | 2 | 0 RUN, 1 IDLE, 2 STANDBY, 3 HALT |
| cpuStall | output | 1 | CPU held off |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| tmr1ClkEn | output | 1 | Timer 1 clock enable |
| wdClkEn | output | 1 | Watchdog clock enable |
| nmiReq | output | 1 | Nonmaskable interrupt request pulse |

## Verification
A control-bit write can land in the same cycle as the idle instruction. The bench provokes this by writing halt-and-power-down while executing idle from a cleared register. The expected result is entry to IDLE with the new bits visible afterwards, and the next idle instruction then reaches HALT. A second collision is a wake from standby or halt that arrives together with the hard-watchdog NMI condition. There the bench expects RUN and a one-cycle `nmiReq` in the same following cycle. A behavioural model, stepped at every clock alongside random stimulus, judges both collisions as well as everything else.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    PS_RUN  = 2'd0,
    PS_IDLE = 2'd1,
    PS_STBY = 2'd2,
    PS_HALT = 2'd3
  } pwrState_t;

  typedef struct packed {
    logic inRun;
    logic inIdle;
    logic inStby;
    logic inHalt;
    logic nmiFire;
  } ctrlStrobe_t;

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        idleExec,
  input  logic        lpDisable,
  input  logic        pdBit,
  input  logic        hsBit,
  input  logic        hardWdMode,
  input  logic        extInt1,
  input  logic        tmr1Int,
  input  logic        anyIntReq,
  output pwrState_t   state,
  output ctrlStrobe_t strobe
);

  pwrState_t stateNext;
  logic      deepSleep;

  always_comb begin
    stateNext = state;
    unique case (state)
      PS_RUN: begin
        if (idleExec) begin
          if (lpDisable || !pdBit) stateNext = PS_IDLE;
          else if (hsBit)          stateNext = PS_HALT;
          else                     stateNext = PS_STBY;
        end
      end
      PS_IDLE: if (anyIntReq)           stateNext = PS_RUN;
      PS_STBY: if (extInt1 || tmr1Int)  stateNext = PS_RUN;
      PS_HALT: if (extInt1)             stateNext = PS_RUN;
      default:                          stateNext = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_RUN;
    else       state <= stateNext;
  end

  assign deepSleep = (state == PS_STBY) || (state == PS_HALT);

  always_comb begin
    strobe.inRun   = (state == PS_RUN);
    strobe.inIdle  = (state == PS_IDLE);
    strobe.inStby  = (state == PS_STBY);
    strobe.inHalt  = (state == PS_HALT);
    strobe.nmiFire = deepSleep && hardWdMode && extInt1;
  end

  // R7: timer 1 and generic interrupts do not end HALT
  p_halt_tmr_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_HALT && !extInt1) |=> (state == PS_HALT));

  // R11: no sleep entry without the idle instruction
  p_run_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_RUN && !idleExec) |=> (state == PS_RUN));

  // R9: disabled deep sleep always lands in IDLE
  p_disable_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_RUN && idleExec && lpDisable) |=> (state == PS_IDLE));

  // R6: standby wakes on either event
  p_stby_wake_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_STBY && (extInt1 || tmr1Int)) |=> (state == PS_RUN));

endmodule

// File: rtl/lpm_dp.sv
module lpm_dp
  import lpm_pkg::*;
#(
  parameter int CFG_W = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             lpDisable,
  input  ctrlStrobe_t      strobe,
  output logic [CFG_W-1:0] ctrlBits,
  output logic             cpuStall,
  output logic             cpuClkEn,
  output logic             periphClkEn,
  output logic             tmr1ClkEn,
  output logic             wdClkEn,
  output logic             nmiReq
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       ctrlBits <= '0;
    else if (cfgWrEn && !lpDisable)  ctrlBits <= cfgWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nmiReq <= 1'b0;
    else       nmiReq <= strobe.nmiFire;
  end

  always_comb begin
    cpuStall    = !strobe.inRun;
    cpuClkEn    = strobe.inRun;
    periphClkEn = strobe.inRun || strobe.inIdle;
    wdClkEn     = strobe.inRun || strobe.inIdle;
    tmr1ClkEn   = !strobe.inHalt;
  end

  // R9: fused-off writes leave the bits alone
  p_bits_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    lpDisable |=> $stable(ctrlBits));

  // R10: the NMI request lasts a single cycle
  p_nmi_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |=> !nmiReq);

  // R4, R5: watchdog clock off whenever the peripherals are gated
  p_wd_follows_periph_r4: assert property (@(posedge clk) disable iff (!rstN)
    !periphClkEn |-> !wdClkEn);

  // R5: timer 1 gating implies everything is gated
  p_halt_all_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    !tmr1ClkEn |-> (!cpuClkEn && !periphClkEn && cpuStall));

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int CFG_W = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             idleExec,
  input  logic             lpDisable,
  input  logic             hardWdMode,
  input  logic             extInt1,
  input  logic             tmr1Int,
  input  logic             anyIntReq,
  output logic [CFG_W-1:0] ctrlBits,
  output logic [STATE_W-1:0] pwrState,
  output logic             cpuStall,
  output logic             cpuClkEn,
  output logic             periphClkEn,
  output logic             tmr1ClkEn,
  output logic             wdClkEn,
  output logic             nmiReq
);

  localparam int PD_IDX = 0;
  localparam int HS_IDX = 1;

  pwrState_t   state;
  ctrlStrobe_t strobe;

  lpm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .idleExec   (idleExec),
    .lpDisable  (lpDisable),
    .pdBit      (ctrlBits[PD_IDX]),
    .hsBit      (ctrlBits[HS_IDX]),
    .hardWdMode (hardWdMode),
    .extInt1    (extInt1),
    .tmr1Int    (tmr1Int),
    .anyIntReq  (anyIntReq),
    .state      (state),
    .strobe     (strobe)
  );

  lpm_dp #(.CFG_W(CFG_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWrEn     (cfgWrEn),
    .cfgWrData   (cfgWrData),
    .lpDisable   (lpDisable),
    .strobe      (strobe),
    .ctrlBits    (ctrlBits),
    .cpuStall    (cpuStall),
    .cpuClkEn    (cpuClkEn),
    .periphClkEn (periphClkEn),
    .tmr1ClkEn   (tmr1ClkEn),
    .wdClkEn     (wdClkEn),
    .nmiReq      (nmiReq)
  );

  assign pwrState = state;

endmodule

// File: tb/lpm_seq_test.sv
module lpm_seq_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgWrEn, idleExec, lpDisable, hardWdMode, extInt1, tmr1Int, anyIntReq;
  logic [1:0] cfgWrData;
  logic [1:0] ctrlBits, pwrState;
  logic       cpuStall, cpuClkEn, periphClkEn, tmr1ClkEn, wdClkEn, nmiReq;

  always #4 clk = ~clk;

  lpm_seq uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .idleExec(idleExec), .lpDisable(lpDisable), .hardWdMode(hardWdMode),
    .extInt1(extInt1), .tmr1Int(tmr1Int), .anyIntReq(anyIntReq),
    .ctrlBits(ctrlBits), .pwrState(pwrState), .cpuStall(cpuStall),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .tmr1ClkEn(tmr1ClkEn),
    .wdClkEn(wdClkEn), .nmiReq(nmiReq)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mState = 0;
  int mBits = 0;
  int mNmi = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected<=20000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cmp(string req, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, name, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    cmp(req, "pwrState", int'(pwrState), mState);
    cmp(req, "ctrlBits", int'(ctrlBits), mBits);
    cmp(req, "cpuStall", int'(cpuStall), (mState != 0) ? 1 : 0);
    cmp(req, "cpuClkEn", int'(cpuClkEn), (mState == 0) ? 1 : 0);
    cmp(req, "periphClkEn", int'(periphClkEn), (mState <= 1) ? 1 : 0);
    cmp(req, "wdClkEn", int'(wdClkEn), (mState <= 1) ? 1 : 0);
    cmp(req, "tmr1ClkEn", int'(tmr1ClkEn), (mState != 3) ? 1 : 0);
    cmp(req, "nmiReq", int'(nmiReq), mNmi);
  endtask

  task automatic clearIn();
    cfgWrEn = 0; cfgWrData = 2'b00; idleExec = 0; extInt1 = 0;
    tmr1Int = 0; anyIntReq = 0;
  endtask

  task automatic modelStep();
    int nx;
    nx = mState;
    mNmi = ((mState == 2 || mState == 3) && hardWdMode && extInt1) ? 1 : 0;
    case (mState)
      0: if (idleExec) nx = (lpDisable || (mBits % 2 == 0)) ? 1 : ((mBits >= 2) ? 3 : 2);
      1: if (anyIntReq) nx = 0;
      2: if (extInt1 || tmr1Int) nx = 0;
      default: if (extInt1) nx = 0;
    endcase
    if (cfgWrEn && !lpDisable) mBits = int'(cfgWrData);
    mState = nx;
  endtask

  task automatic step(string req);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checkAll(req);
    clearIn();
  endtask

  task automatic doReset(string req);
    rstN = 0;
    mState = 0; mBits = 0; mNmi = 0;
    #1;
    checkAll(req);
    @(negedge clk);
    rstN = 1;
    checkAll(req);
  endtask

  task automatic wr(int bits, string req);
    cfgWrEn = 1; cfgWrData = bits[1:0];
    step(req);
  endtask

  initial begin
    rstN = 0; lpDisable = 0; hardWdMode = 0;
    clearIn();
    repeat (2) @(negedge clk);
    doReset("R1");
    step("R1");

    wr(1, "R2");
    wr(2, "R2");
    idleExec = 1; step("R3");
    extInt1 = 1; step("R8");
    tmr1Int = 1; step("R8");
    idleExec = 1; step("R11");
    anyIntReq = 1; step("R8");

    wr(1, "R2");
    idleExec = 1; step("R4");
    tmr1Int = 1; step("R6");
    idleExec = 1; step("R4");
    extInt1 = 1; step("R6");

    wr(3, "R2");
    idleExec = 1; step("R5");
    tmr1Int = 1; step("R7");
    anyIntReq = 1; step("R7");
    idleExec = 1; step("R11");
    extInt1 = 1; step("R7");
    step("R12");

    hardWdMode = 1;
    idleExec = 1; step("R5");
    extInt1 = 1; step("R10");
    step("R10");
    wr(1, "R2");
    idleExec = 1; step("R4");
    extInt1 = 1; tmr1Int = 1; step("R10");
    hardWdMode = 0;
    idleExec = 1; step("R4");
    extInt1 = 1; step("R10");

    lpDisable = 1;
    wr(3, "R9");
    wr(0, "R9");
    idleExec = 1; step("R9");
    anyIntReq = 1; step("R9");
    lpDisable = 0;

    wr(0, "R2");
    cfgWrEn = 1; cfgWrData = 2'b11; idleExec = 1; step("R12");
    anyIntReq = 1; step("R12");
    idleExec = 1; step("R12");

    @(negedge clk);
    doReset("R1");
    step("R1");

    for (int i = 0; i < 3000; i++) begin
      cfgWrEn   = ($urandom_range(0, 9) == 0);
      cfgWrData = 2'($urandom_range(0, 3));
      idleExec  = ($urandom_range(0, 3) == 0);
      extInt1   = ($urandom_range(0, 7) == 0);
      tmr1Int   = ($urandom_range(0, 5) == 0);
      anyIntReq = ($urandom_range(0, 5) == 0);
      lpDisable = ($urandom_range(0, 15) == 0);
      hardWdMode = ($urandom_range(0, 1) == 0);
      step("R12");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule